// File: doc/BRIEF.md
# Program Sequencer with Hardware Return Stack

This block keeps the fetch address of a small accumulator-style controller core and decides, each cycle, where the next fetch goes. It holds a 13-bit program counter and an eight-slot return stack. The instruction decoder drives a 3-bit operation code each cycle. The block either holds the counter, steps it, branches to a page-relative target, calls or returns from a subroutine, takes an interrupt, returns from one, or loads the counter from a computed low byte. The upper bits of branch and computed targets come from a separately written 5-bit high-address latch, never from the data bus.

The stack is a fixed ring that software cannot see. A push always writes; a ninth push silently replaces the oldest return address. A pop always reads; popping an empty stack returns whatever slot the ring pointer wraps onto. A return that also carries a literal moves the counter exactly like a plain return, so the decoder issues the plain return code for it. Every port is a plain per-cycle control or data pin, so the block has no flow-control handshake. An operation takes effect at the clock edge where it is presented.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted and after it is released, fetch_addr reads 0000h and gie_reen reads 0 until an operation changes them; all stack slots are cleared to 0000h.
- R2: op=1 (step) loads fetch_addr+1, wrapping from 1FFFh to 0000h.
- R3: op=0 (hold) leaves fetch_addr unchanged.
- R4: op=2 (branch) loads fetch_addr[12:11] from hi_latch[4:3] and fetch_addr[10:0] from jump_tgt.
- R5: op=3 (call) pushes fetch_addr+1 onto the return stack and loads the counter as in R4.
- R6: op=4 (return, also used for a return carrying a literal) loads the counter from the most recent stack entry and removes it.
- R7: op=6 (interrupt entry) pushes the current fetch_addr and loads 0004h.
- R8: op=5 (interrupt return) pops like R6. gie_reen is 1 for exactly the one cycle that follows that edge, and it is 1 at no other time.
- R9: op=7 (low-byte write) loads fetch_addr[7:0] from low_data and fetch_addr[12:8] from hi_latch[4:0].
- R10: After nine pushes with no pops, the ninth value has replaced the first. Eight pops return the values pushed ninth back to second, and a further pop returns the ninth value again. A pop right after reset returns 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code from the decoder (encodings in R2 to R9) |
| jump_tgt | input | 11 | In-page target of a branch or call |
| hi_latch | input | 5 | High-address latch value |
| low_data | input | 8 | Data bus value for a low-byte write |
| fetch_addr | output | 13 | Current program counter |
| gie_reen | output | 1 | One-cycle pulse re-enabling global interrupts |

## Verification
The hardest state to reach from the ports is a stack that has wrapped. A nested-call sequence of nine calls with distinct targets fills the ring and then overwrites its oldest slot. Nine returns then walk the ring back past its start, so both the overwrite and the pointer wrap on underflow show up on fetch_addr. A fresh reset followed by an immediate return reaches the empty-stack pop.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_STEP   = 3'd1,
    OP_BRANCH = 3'd2,
    OP_CALL   = 3'd3,
    OP_RET    = 3'd4,
    OP_IRET   = 3'd5,
    OP_IRQ    = 3'd6,
    OP_LOWWR  = 3'd7
  } seq_op_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_val,
  input  logic              pop_en,
  output logic [ADDR_W-1:0] top_val
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_ptr;

  // the newest entry sits one below the write pointer; wraps freely
  assign rd_ptr  = wr_ptr_q - PTR_W'(1);
  assign top_val = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (push_en) begin
      slot_q[wr_ptr_q] <= push_val;
      wr_ptr_q         <= wr_ptr_q + PTR_W'(1);
    end else if (pop_en) begin
      wr_ptr_q <= rd_ptr;
    end
  end
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TGT_W  = 11,
  parameter int LAT_W  = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 13'h0004
) (
  input  seq_op_e           op,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [LAT_W-1:0]  latch,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] stack_top,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic              push_en,
  output logic [ADDR_W-1:0] push_val,
  output logic              pop_en
);
  localparam int PAGE_W = ADDR_W - TGT_W;

  logic [ADDR_W-1:0] inc_pc;
  logic [ADDR_W-1:0] paged_tgt;

  assign inc_pc    = cur_pc + ADDR_W'(1);
  assign paged_tgt = {latch[LAT_W-1 -: PAGE_W], tgt};

  always_comb begin
    nxt_pc   = cur_pc;
    push_en  = 1'b0;
    push_val = inc_pc;
    pop_en   = 1'b0;
    unique case (op)
      OP_HOLD:   nxt_pc = cur_pc;
      OP_STEP:   nxt_pc = inc_pc;
      OP_BRANCH: nxt_pc = paged_tgt;
      OP_CALL: begin
        nxt_pc  = paged_tgt;
        push_en = 1'b1;
      end
      OP_RET, OP_IRET: begin
        nxt_pc = stack_top;
        pop_en = 1'b1;
      end
      OP_IRQ: begin
        nxt_pc   = IRQ_VEC;
        push_en  = 1'b1;
        push_val = cur_pc;
      end
      OP_LOWWR:  nxt_pc = {latch, data};
      default:   nxt_pc = cur_pc;
    endcase
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8,
  parameter int TGT_W  = 11,
  parameter int LAT_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [TGT_W-1:0]  jump_tgt,
  input  logic [LAT_W-1:0]  hi_latch,
  input  logic [DATA_W-1:0] low_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              gie_reen
);
  seq_op_e           op_e;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              push_en;
  logic              pop_en;
  logic [ADDR_W-1:0] push_val;
  logic [ADDR_W-1:0] stack_top;
  logic              gie_q;

  assign op_e = seq_op_e'(op);

  pcs_next_pc #(
    .ADDR_W(ADDR_W), .TGT_W(TGT_W), .LAT_W(LAT_W), .DATA_W(DATA_W),
    .IRQ_VEC(ADDR_W'(4))
  ) u_next (
    .op(op_e), .cur_pc(pc_q), .tgt(jump_tgt), .latch(hi_latch),
    .data(low_data), .stack_top(stack_top), .nxt_pc(pc_d),
    .push_en(push_en), .push_val(push_val), .pop_en(pop_en)
  );

  pcs_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_val(push_val),
    .pop_en(pop_en), .top_val(stack_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      gie_q <= (op_e == OP_IRET);
    end
  end

  assign fetch_addr = pc_q;
  assign gie_reen   = gie_q;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int TGT_W  = 11,
  parameter int LAT_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op,
  input logic [TGT_W-1:0]  jump_tgt,
  input logic [LAT_W-1:0]  hi_latch,
  input logic [DATA_W-1:0] low_data,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              gie_reen
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd1 |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |=> $stable(fetch_addr));

  a_r4_branch: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd2 |=> fetch_addr[TGT_W-1:0] == $past(jump_tgt)
                && fetch_addr[ADDR_W-1:TGT_W] == $past(hi_latch[LAT_W-1 -: ADDR_W-TGT_W]));

  a_r7_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd6 |=> fetch_addr == ADDR_W'(4));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 |=> gie_reen);

  a_r8_only_after_iret: assert property (@(posedge clk) disable iff (!rst_n)
    gie_reen |-> $past(op) == 3'd5);

  a_r9_lowwr: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd7 |=> fetch_addr == {$past(hi_latch), $past(low_data)});
endmodule

bind prog_seq prog_seq_chk #(
  .ADDR_W(ADDR_W), .TGT_W(TGT_W), .LAT_W(LAT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .jump_tgt(jump_tgt),
  .hi_latch(hi_latch), .low_data(low_data), .fetch_addr(fetch_addr),
  .gie_reen(gie_reen)
);

// File: tb/prog_seq_tb.sv
module prog_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [10:0] jump_tgt = '0;
  logic [4:0]  hi_latch = '0;
  logic [7:0]  low_data = '0;
  logic [12:0] fetch_addr;
  logic        gie_reen;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .jump_tgt(jump_tgt),
    .hi_latch(hi_latch), .low_data(low_data), .fetch_addr(fetch_addr),
    .gie_reen(gie_reen)
  );

  // row: op[40:38] tgt[37:27] latch[26:22] data[21:14] exp_pc[13:1] exp_gie[0]
  localparam logic [40:0] VEC [16] = '{
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h0001, 1'b0},  // R2
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h0002, 1'b0},  // R2
    {3'd2, 11'h123, 5'h18, 8'h00, 13'h1923, 1'b0},  // R4
    {3'd3, 11'h045, 5'h08, 8'h00, 13'h0845, 1'b0},  // R5 push 1924
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h0846, 1'b0},  // R2
    {3'd6, 11'h000, 5'h00, 8'h00, 13'h0004, 1'b0},  // R7 push 0846
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h0005, 1'b0},  // R2
    {3'd5, 11'h000, 5'h00, 8'h00, 13'h0846, 1'b1},  // R8
    {3'd4, 11'h000, 5'h00, 8'h00, 13'h1924, 1'b0},  // R6
    {3'd7, 11'h000, 5'h1F, 8'hFE, 13'h1FFE, 1'b0},  // R9
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h1FFF, 1'b0},  // R2
    {3'd1, 11'h000, 5'h00, 8'h00, 13'h0000, 1'b0},  // R2 wrap
    {3'd0, 11'h7AA, 5'h1F, 8'hAA, 13'h0000, 1'b0},  // R3
    {3'd7, 11'h000, 5'h05, 8'h3C, 13'h053C, 1'b0},  // R9
    {3'd2, 11'h7FF, 5'h07, 8'h00, 13'h07FF, 1'b0},  // R4 latch low bits ignored
    {3'd0, 11'h000, 5'h00, 8'h00, 13'h07FF, 1'b0}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(input logic [2:0] o, input logic [10:0] t,
                       input logic [4:0] l, input logic [7:0] d);
    op = o; jump_tgt = t; hi_latch = l; low_data = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    check("R1 pc", fetch_addr, 0);
    check("R1 gie", gie_reen, 0);

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][40:38], VEC[i][37:27], VEC[i][26:22], VEC[i][21:14]);
      check($sformatf("vec%0d pc", i), fetch_addr, VEC[i][13:1]);
      check($sformatf("vec%0d gie (R8)", i), gie_reen, VEC[i][0]);
    end

    // R8: pulse lasts one cycle only
    apply(3'd5, '0, '0, '0);
    check("R8 pulse high", gie_reen, 1);
    apply(3'd0, '0, '0, '0);
    check("R8 pulse gone", gie_reen, 0);

    // R10/R1: pop right after reset returns cleared slot
    do_reset();
    apply(3'd4, '0, '0, '0);
    check("R10 empty pop", fetch_addr, 0);

    // R10: nine nested calls, then nine returns
    do_reset();
    for (int i = 1; i <= 9; i++) begin
      apply(3'd3, 11'(i * 16), 5'h00, '0);
      check("R5 call target", fetch_addr, i * 16);
    end
    for (int j = 0; j < 8; j++) begin
      apply(3'd4, '0, '0, '0);
      check("R10 wrapped pop", fetch_addr, (8 - j) * 16 + 1);
    end
    apply(3'd4, '0, '0, '0);
    check("R10 ninth pop", fetch_addr, 8'h81);

    // R7: interrupt pushes current address, R8 returns to it
    apply(3'd6, '0, '0, '0);
    check("R7 vector", fetch_addr, 4);
    apply(3'd5, '0, '0, '0);
    check("R8 return addr", fetch_addr, 8'h81);

    finish_up();
  end
endmodule